// File: doc/BRIEF.md
# Window Scan Address Generator

This block produces the address stream that reads a rectangular region of interest out of a 640 by 480 pixel array. Columns are addressed in groups of 8 adjacent pixels, one group per clock. The window width is requested as a number of 4-pixel kernels. The group address therefore runs over whole groups, and a per-beat pixel mask marks which of the 8 pixels in the current group belong to the window. Rows are addressed one line at a time.

A single-cycle frame-start pulse, seen while the generator is idle, captures the whole configuration. The generator then walks the window line by line. Either axis may be walked backwards; mirroring changes only the order of the walk, and the window stays in the same place. A programmable number of idle clocks separates consecutive lines. End-of-line marks the last group of each line. End-of-frame marks the last group of the last line, and the generator then returns to idle.

Top module: `roi_scan_gen`

## Requirements
- R1: While reset is held and after its release, the generator is idle: `busy`, `pix_valid`, `eol` and `eof` are 0 and `pix_mask` is all zeros.
- R2: A `frame_start` pulse sampled while idle makes `pix_valid` and `busy` 1 on the next clock, with the first address of the window on `col_grp` and `row_addr`. A `frame_start` seen while `busy` is 1 has no effect.
- R3: With `cfg_flip_x`=0, `col_grp` runs up by one per valid beat. It starts at the column start group and ends at the group that holds pixel 8*start + 4*kernels - 1. A kernel count of 0 is treated as 1.
- R4: During a valid beat, `pix_mask` bit i is 1 exactly when pixel 8*`col_grp`+i lies inside the window. For example, start 23 with 37 kernels gives groups 23 to 41, and the last group has mask 8'h0F.
- R5: With `cfg_flip_y`=0, `row_addr` runs from the row start up to row start + row count - 1, with one row per line. `row_addr` is held for the whole line. A row count of 0 is treated as 1.
- R6: With `cfg_flip_x`=1, each line covers the same groups as in R3, but the walk starts at the last group and steps down to the start group.
- R7: With `cfg_flip_y`=1, the frame covers the same rows as in R5, but the walk starts at the last row and steps down to the row start.
- R8: A column start above 79 is taken as 79 and a row start above 479 is taken as 479. Window ends beyond pixel 639 or row 479 are cut back to those edges.
- R9: Between the last beat of one line and the first beat of the next, `pix_valid` is 0 for exactly `cfg_gap` clocks. With a gap of 0 the lines follow back to back.
- R10: `eol` is 1 on the last beat of each line. `eof` is 1 only together with `eol` on the last line. On the clock after `eof` the generator is idle.
- R11: Configuration inputs are sampled only when a frame is accepted. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, must be released synchronously |
| frame_start | input | 1 | Single-cycle request to scan one frame |
| cfg_col_start | input | 7 | First column group (0 to 79) |
| cfg_row_start | input | 9 | First row (0 to 479) |
| cfg_kernels | input | 8 | Window width in 4-pixel kernels (1 to 160) |
| cfg_rows | input | 9 | Window height in rows |
| cfg_flip_x | input | 1 | 1: walk the columns right to left |
| cfg_flip_y | input | 1 | 1: walk the rows bottom to top |
| cfg_gap | input | 8 | Idle clocks between lines |
| col_grp | output | 7 | Current column group address |
| row_addr | output | 9 | Current row address |
| pix_mask | output | 8 | Pixels of the current group inside the window |
| pix_valid | output | 1 | Address beat valid |
| eol | output | 1 | Last beat of a line |
| eof | output | 1 | Last beat of the frame |
| busy | output | 1 | Frame in progress |

## Verification
Every output comes from registers that are loaded on the edge where `frame_start` is accepted. The first beat is therefore due one clock after the pulse, and each later beat one clock after the previous one. Each gap adds exactly `cfg_gap` empty clocks, and the idle state follows one clock after `eof`. The bench drives its inputs on falling edges and predicts every clock of the frame: each beat, each gap clock and the trailing idle clock. It compares the outputs at the falling edge that follows the rising edge which produced them, so every expectation lines up with a known register stage.

// File: rtl/roi_pkg.sv
package roi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } scan_st_e;
endpackage

// File: rtl/roi_window_calc.sv
// Turns raw configuration into clamped column-group and row limits.
module roi_window_calc #(
  parameter int ARR_W   = 640,
  parameter int ARR_H   = 480,
  parameter int GRP_PIX = 8,
  parameter int KER_PIX = 4,
  parameter int GW      = 7,
  parameter int RW      = 9,
  parameter int PXW     = 10,
  parameter int KW      = 8
) (
  input  logic [GW-1:0]  col_start,
  input  logic [RW-1:0]  row_start,
  input  logic [KW-1:0]  kernels,
  input  logic [RW-1:0]  rows,
  output logic [GW-1:0]  col_lo,
  output logic [GW-1:0]  col_hi,
  output logic [RW-1:0]  row_lo,
  output logic [RW-1:0]  row_hi,
  output logic [PXW-1:0] pix_end
);
  localparam int NGRP = ARR_W / GRP_PIX;
  localparam int EW   = PXW + KW + 2;
  localparam int RW1  = RW + 1;

  logic [GW-1:0] cs;
  logic [EW-1:0] kc, px0, raw_end, end_c, end_m1;
  logic [RW-1:0] rs, rc;
  logic [RW:0]   rend;

  always_comb begin
    cs      = (col_start > GW'(NGRP - 1)) ? GW'(NGRP - 1) : col_start;
    kc      = (kernels == '0) ? EW'(1) : EW'(kernels);
    px0     = EW'(cs) * EW'(GRP_PIX);
    raw_end = px0 + kc * EW'(KER_PIX);
    end_c   = (raw_end > EW'(ARR_W)) ? EW'(ARR_W) : raw_end;
    end_m1  = end_c - EW'(1);
    col_lo  = cs;
    col_hi  = GW'(end_m1 / EW'(GRP_PIX));
    pix_end = PXW'(end_c);
    rs      = (row_start > RW'(ARR_H - 1)) ? RW'(ARR_H - 1) : row_start;
    rc      = (rows == '0) ? RW'(1) : rows;
    rend    = {1'b0, rs} + {1'b0, rc} - RW1'(1);
    row_lo  = rs;
    row_hi  = (rend > RW1'(ARR_H - 1)) ? RW'(ARR_H - 1) : rend[RW-1:0];
  end
endmodule

// File: rtl/roi_axis_ctr.sv
// Loadable up/down position counter with an end-of-range compare.
module roi_axis_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         dec,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] end_val,
  output logic [W-1:0] pos,
  output logic         at_end
);
  logic [W-1:0] pos_d;
  logic         pos_en;

  always_comb begin
    pos_en = load || step;
    pos_d  = pos;
    if (load)      pos_d = ld_val;
    else if (step) pos_d = dec ? pos - 1'b1 : pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= '0;
    else if (pos_en) pos <= pos_d;
  end

  assign at_end = (pos == end_val);
endmodule

// File: rtl/roi_scan_fsm.sv
// Frame sequencer: idle, scanning a line, inter-line gap.
module roi_scan_fsm
  import roi_pkg::*;
#(
  parameter int GAPW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            col_end,
  input  logic            row_end,
  input  logic [GAPW-1:0] gap_val,
  output logic            accept,
  output logic            run
);
  scan_st_e        st_q, st_d;
  logic [GAPW-1:0] gcnt_q, gcnt_d;
  logic            gcnt_en;

  always_comb begin
    st_d    = st_q;
    gcnt_d  = gcnt_q;
    gcnt_en = 1'b0;
    accept  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (frame_start) begin
        accept = 1'b1;
        st_d   = ST_RUN;
      end
      ST_RUN: if (col_end) begin
        if (row_end)             st_d = ST_IDLE;
        else if (gap_val != '0) begin
          st_d    = ST_GAP;
          gcnt_d  = gap_val;
          gcnt_en = 1'b1;
        end
      end
      ST_GAP: begin
        gcnt_en = 1'b1;
        gcnt_d  = gcnt_q - 1'b1;
        if (gcnt_q == GAPW'(1)) st_d = ST_RUN;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      gcnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (gcnt_en) gcnt_q <= gcnt_d;
    end
  end

  assign run = (st_q == ST_RUN);
endmodule

// File: rtl/roi_scan_gen.sv
// Region-of-interest address generator (top).
module roi_scan_gen #(
  parameter int ARR_W   = 640,
  parameter int ARR_H   = 480,
  parameter int GRP_PIX = 8,
  parameter int KER_PIX = 4,
  parameter int KW      = 8,
  parameter int GAPW    = 8,
  localparam int NGRP   = ARR_W / GRP_PIX,
  localparam int GW     = $clog2(NGRP),
  localparam int RW     = $clog2(ARR_H),
  localparam int PXW    = $clog2(ARR_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [GW-1:0]      cfg_col_start,
  input  logic [RW-1:0]      cfg_row_start,
  input  logic [KW-1:0]      cfg_kernels,
  input  logic [RW-1:0]      cfg_rows,
  input  logic               cfg_flip_x,
  input  logic               cfg_flip_y,
  input  logic [GAPW-1:0]    cfg_gap,
  output logic [GW-1:0]      col_grp,
  output logic [RW-1:0]      row_addr,
  output logic [GRP_PIX-1:0] pix_mask,
  output logic               pix_valid,
  output logic               eol,
  output logic               eof,
  output logic               busy
);
  logic [GW-1:0]   c_lo, c_hi, col_lo_q, col_hi_q;
  logic [RW-1:0]   r_lo, r_hi, row_lo_q, row_hi_q;
  logic [PXW-1:0]  p_end, pix_end_q;
  logic            flip_x_q, flip_y_q;
  logic [GAPW-1:0] gap_q;
  logic            accept, run, col_end, row_end;
  logic            col_load, col_step, row_step;
  logic [GW-1:0]   col_ld, col_stop;
  logic [RW-1:0]   row_ld, row_stop;
  logic [PXW-1:0]  grp_px;
  logic            active_q;

  roi_window_calc #(
    .ARR_W(ARR_W), .ARR_H(ARR_H), .GRP_PIX(GRP_PIX), .KER_PIX(KER_PIX),
    .GW(GW), .RW(RW), .PXW(PXW), .KW(KW)
  ) u_calc (
    .col_start(cfg_col_start), .row_start(cfg_row_start),
    .kernels(cfg_kernels), .rows(cfg_rows),
    .col_lo(c_lo), .col_hi(c_hi), .row_lo(r_lo), .row_hi(r_hi),
    .pix_end(p_end)
  );

  // configuration captured once per accepted frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_lo_q  <= '0;
      col_hi_q  <= '0;
      row_lo_q  <= '0;
      row_hi_q  <= '0;
      pix_end_q <= '0;
      flip_x_q  <= 1'b0;
      flip_y_q  <= 1'b0;
      gap_q     <= '0;
    end else if (accept) begin
      col_lo_q  <= c_lo;
      col_hi_q  <= c_hi;
      row_lo_q  <= r_lo;
      row_hi_q  <= r_hi;
      pix_end_q <= p_end;
      flip_x_q  <= cfg_flip_x;
      flip_y_q  <= cfg_flip_y;
      gap_q     <= cfg_gap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= accept || (active_q && !(run && col_end && row_end));
  end

  always_comb begin
    col_load = accept || (run && col_end);
    col_step = run && !col_end;
    row_step = run && col_end && !row_end;
    col_ld   = accept ? (cfg_flip_x ? c_hi : c_lo)
                      : (flip_x_q ? col_hi_q : col_lo_q);
    col_stop = flip_x_q ? col_lo_q : col_hi_q;
    row_ld   = cfg_flip_y ? r_hi : r_lo;
    row_stop = flip_y_q ? row_lo_q : row_hi_q;
  end

  roi_axis_ctr #(.W(GW)) u_col (
    .clk(clk), .rst_n(rst_n), .load(col_load), .step(col_step),
    .dec(flip_x_q), .ld_val(col_ld), .end_val(col_stop),
    .pos(col_grp), .at_end(col_end)
  );

  roi_axis_ctr #(.W(RW)) u_row (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(row_step),
    .dec(flip_y_q), .ld_val(row_ld), .end_val(row_stop),
    .pos(row_addr), .at_end(row_end)
  );

  roi_scan_fsm #(.GAPW(GAPW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .col_end(col_end), .row_end(row_end), .gap_val(gap_q),
    .accept(accept), .run(run)
  );

  assign pix_valid = run;
  assign eol       = run && col_end;
  assign eof       = run && col_end && row_end;
  assign busy      = active_q;
  assign grp_px    = PXW'(col_grp) * PXW'(GRP_PIX);

  for (genvar i = 0; i < GRP_PIX; i++) begin : g_mask
    assign pix_mask[i] = run && ((grp_px + PXW'(i)) < pix_end_q);
  end
endmodule

// File: rtl/roi_scan_chk.sv
// Protocol checker bound to the address generator.
module roi_scan_chk #(
  parameter int GW      = 7,
  parameter int RW      = 9,
  parameter int GRP_PIX = 8,
  parameter int GAPW    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic [GW-1:0]      col_grp,
  input logic [RW-1:0]      row_addr,
  input logic [GRP_PIX-1:0] pix_mask,
  input logic               pix_valid,
  input logic               eol,
  input logic               eof,
  input logic               busy,
  input logic [GAPW-1:0]    gap_q
);
  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !busy |=> pix_valid && busy); // R2
  AST_COL_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !eol |=> pix_valid &&
      (col_grp == $past(col_grp) + 1'b1 || col_grp == $past(col_grp) - 1'b1)); // R3
  AST_MASK_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> pix_mask[0]); // R4
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> pix_mask == '0); // R4
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !eol |=> $stable(row_addr)); // R5
  AST_ROW_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    eol && !eof && gap_q == '0 |=> pix_valid &&
      (row_addr == $past(row_addr) + 1'b1 || row_addr == $past(row_addr) - 1'b1)); // R5
  AST_GAP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    eol && !eof && gap_q != '0 |=> !pix_valid && busy); // R9
  AST_EOF_WITH_EOL: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> eol); // R10
  AST_EOL_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    eol |-> pix_valid); // R10
  AST_IDLE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !busy && !pix_valid); // R10
endmodule

bind roi_scan_gen roi_scan_chk #(
  .GW(GW), .RW(RW), .GRP_PIX(GRP_PIX), .GAPW(GAPW)
) u_chk (.*);

// File: tb/roi_scan_gen_bench.sv
module roi_scan_gen_bench;
  logic       clk;
  logic       rst_n;
  logic       frame_start;
  logic [6:0] cfg_col_start;
  logic [8:0] cfg_row_start;
  logic [7:0] cfg_kernels;
  logic [8:0] cfg_rows;
  logic       cfg_flip_x, cfg_flip_y;
  logic [7:0] cfg_gap;
  logic [6:0] col_grp;
  logic [8:0] row_addr;
  logic [7:0] pix_mask;
  logic       pix_valid, eol, eof, busy;

  int n_vec = 0;
  int n_bad = 0;

  roi_scan_gen u_roi_scan_gen (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_col_start(cfg_col_start), .cfg_row_start(cfg_row_start),
    .cfg_kernels(cfg_kernels), .cfg_rows(cfg_rows),
    .cfg_flip_x(cfg_flip_x), .cfg_flip_y(cfg_flip_y), .cfg_gap(cfg_gap),
    .col_grp(col_grp), .row_addr(row_addr), .pix_mask(pix_mask),
    .pix_valid(pix_valid), .eol(eol), .eof(eof), .busy(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // one frame, checked on every clock from the first beat to the idle clock
  task automatic run_frame(input int cs, input int rs, input int k, input int nr,
                           input bit fx, input bit fy, input int gap,
                           input string ctag, input string rtag, input bit disturb);
    int cs_c, k_c, pend, glo, ghi, rs_c, nr_c, rlo, rhi, ncols, nrows;
    cs_c  = min_i(cs, 79);
    k_c   = (k == 0) ? 1 : k;
    pend  = min_i(cs_c * 8 + k_c * 4, 640);
    glo   = cs_c;
    ghi   = (pend - 1) / 8;
    rs_c  = min_i(rs, 479);
    nr_c  = (nr == 0) ? 1 : nr;
    rlo   = rs_c;
    rhi   = min_i(rs_c + nr_c - 1, 479);
    ncols = ghi - glo + 1;
    nrows = rhi - rlo + 1;
    @(negedge clk);
    cfg_col_start = 7'(cs);  cfg_row_start = 9'(rs);
    cfg_kernels   = 8'(k);   cfg_rows      = 9'(nr);
    cfg_flip_x    = fx;      cfg_flip_y    = fy;
    cfg_gap       = 8'(gap); frame_start   = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check("R2", "first beat valid", int'(pix_valid), 1);
    for (int ri = 0; ri < nrows; ri++) begin
      for (int ci = 0; ci < ncols; ci++) begin
        int g, r, m;
        bit last_c, last_r;
        if (ri != 0 || ci != 0) begin
          @(negedge clk);
          frame_start = 1'b0;
          check(ctag, "valid", int'(pix_valid), 1);
        end
        g = fx ? ghi - ci : glo + ci;
        r = fy ? rhi - ri : rlo + ri;
        m = 0;
        for (int b = 0; b < 8; b++) if (g * 8 + b < pend) m |= (1 << b);
        last_c = (ci == ncols - 1);
        last_r = (ri == nrows - 1);
        check(ctag, "col_grp", int'(col_grp), g);
        check(rtag, "row_addr", int'(row_addr), r);
        check("R4", "pix_mask", int'(pix_mask), m);
        check("R10", "eol", int'(eol), int'(last_c));
        check("R10", "eof", int'(eof), int'(last_c && last_r));
        if (disturb && ri == 0 && ci == 1) begin
          // R11: new settings and a second start pulse mid-frame
          cfg_col_start = 7'd3;  cfg_row_start = 9'd200;
          cfg_kernels   = 8'd99; cfg_rows      = 9'd40;
          cfg_flip_x    = ~fx;   cfg_flip_y    = ~fy;
          cfg_gap       = 8'd0;  frame_start   = 1'b1;
        end
      end
      if (ri != nrows - 1) begin
        for (int q = 0; q < gap; q++) begin
          @(negedge clk);
          frame_start = 1'b0;
          check("R9", "valid in gap", int'(pix_valid), 0);
        end
      end
    end
    @(negedge clk);
    frame_start = 1'b0;
    check("R10", "busy after eof", int'(busy), 0);
    check("R10", "valid after eof", int'(pix_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    rst_n = 1'b0; frame_start = 1'b0;
    cfg_col_start = '0; cfg_row_start = '0; cfg_kernels = 8'd1; cfg_rows = 9'd1;
    cfg_flip_x = 1'b0; cfg_flip_y = 1'b0; cfg_gap = '0;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "valid in reset", int'(pix_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "valid after reset", int'(pix_valid), 0);
    check("R1", "mask after reset", int'(pix_mask), 0);
    check("R1", "eof after reset", int'(eof), 0);

    // directed corner cases
    run_frame(23, 10, 37, 3, 1'b0, 1'b0, 2, "R3", "R5", 1'b0);   // R4 mask 0x0F at group 41
    run_frame(23, 10, 37, 2, 1'b1, 1'b0, 1, "R6", "R5", 1'b0);
    run_frame(5, 100, 3, 4, 1'b0, 1'b1, 3, "R3", "R7", 1'b0);
    run_frame(79, 478, 160, 5, 1'b1, 1'b1, 1, "R8", "R8", 1'b0);
    run_frame(100, 500, 2, 3, 1'b0, 1'b0, 0, "R8", "R8", 1'b0);
    run_frame(0, 0, 0, 0, 1'b0, 1'b0, 4, "R3", "R5", 1'b0);      // zero counts act as 1
    run_frame(10, 20, 6, 4, 1'b0, 1'b0, 0, "R9", "R9", 1'b0);     // back-to-back lines
    run_frame(12, 30, 9, 3, 1'b0, 1'b1, 2, "R11", "R11", 1'b1);   // R11 and ignored start

    // constrained random frames
    for (int t = 0; t < 40; t++) begin
      int cs, rs, k, nr, gp;
      bit fx, fy;
      cs = int'($urandom_range(0, 79));
      rs = int'($urandom_range(0, 479));
      k  = int'($urandom_range(1, 24));
      nr = int'($urandom_range(1, 6));
      gp = int'($urandom_range(0, 5));
      fx = 1'($urandom_range(0, 1));
      fy = 1'($urandom_range(0, 1));
      run_frame(cs, rs, k, nr, fx, fy, gp, fx ? "R6" : "R3", fy ? "R7" : "R5", 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule